// File: doc/BRIEF.md
# Multiplexed LCD Drive Level Sequencer

This block converts stored display data into drive-level codes for three backplane outputs and a parameterised number of segment outputs (32 by default). An external analog selector turns each code into one of five voltages. The block counts down the oscillator clock to frame timing. It then steps through one backplane time slot after another. Each slot is split into two halves of opposite polarity, so the average voltage across every pixel is zero. The mode input sets the number of backplanes and the bias scheme: one plane with two levels, two planes with half bias, or three planes with third bias.

Display data arrives in parallel from an external serial shift register, together with that interface's enable. A display latch copies the data only on the last clock of a frame, and only while the enable is low. A display that is being refreshed therefore never tears inside a frame. Power-down and the reserved mode value blank all outputs and hold the timing at its start.

Top module: `lcd_level_seq`

## Requirements
- R1: While `rst_n` is low, every backplane and segment output is code 0 (VSS), and the display latch is cleared to all zeros.
- R2: While `pwr_dn` is high, or `mode` is 00, every output reads code 0 from the next clock on, and the timing is held at its start. When both return to a running setting, timing restarts at slot 0, first half.
- R3: A frame lasts `FRAME_DIV` clocks. The 1, 2 or 3 backplanes (mode 01, 10, 11) each own one slot of `FRAME_DIV`/planes clocks, in order plane 0, 1, 2. Each slot is split into two equal halves.
- R4: Level codes are 0=VSS, 1=one third, 2=half, 3=two thirds, 4=VLCD. The backplane whose slot is active drives code 4 in the first half and code 0 in the second half. At most one backplane drives code 4 at any time.
- R5: Idle backplanes are parked by mode. In mode 01, planes 1 and 2 stay at code 0. In mode 10, the idle plane of 0/1 and plane 2 stay at code 2. In mode 11, idle planes drive code 1 in the first half and code 3 in the second half.
- R6: A segment whose pixel for the active plane is 1 drives the opposite of the active backplane: code 0 in the first half and code 4 in the second half.
- R7: A segment whose pixel is 0 drives as follows. In mode 01 it follows the backplane (code 4, then 0). In mode 10 it drives code 2. In mode 11 it drives code 3, then code 1.
- R8: The pixel for segment n on backplane k is `shift_data[k*SEG_COUNT + n]`. Mode 01 uses only k=0, and mode 10 uses k=0 and k=1.
- R9: The latch copies `shift_data` only on the clock edge that ends a frame, and only if `shift_en` is low at that edge. At every other edge, and whenever `shift_en` is high, its contents are unchanged.
- R10: A change of `mode` restarts the timing. The next cycle is blank (all code 0), and the cycle after that starts at slot 0, first half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Power-down: blank outputs, hold timing |
| mode | input | 2 | 00 off, 01 one plane, 10 two planes half bias, 11 three planes third bias |
| shift_en | input | 1 | Serial shift in progress; blocks latch transfer |
| shift_data | input | 3*SEG_COUNT | Parallel contents of the external shift register |
| bp_lvl | output | 9 | Backplane level codes, plane k at bits [3k+2:3k] |
| seg_lvl | output | 3*SEG_COUNT | Segment level codes, segment n at bits [3n+2:3n] |

## Verification
The hardest case to reach from the ports is the frame-end edge itself. `shift_en` must fall, or rise, on exactly the one clock that closes a frame, and a mode change must land partway through a slot. The bench keeps its own count of frame position from the configuration it has applied. It uses that count to open a one-cycle enable window on the closing clock, and to close one on that clock alone. Long random runs then toggle the enable and switch modes and power-down at arbitrary points, against an independently computed waveform.

// File: rtl/lcd_level_seq_pkg.sv
package lcd_level_seq_pkg;

  localparam int LVL_W  = 3;
  localparam int PLANES = 3;

  typedef enum logic [LVL_W-1:0] {
    LV_VSS      = 3'd0,
    LV_THIRD    = 3'd1,
    LV_HALF     = 3'd2,
    LV_TWOTHIRD = 3'd3,
    LV_VLCD     = 3'd4
  } lvl_e;

  typedef enum logic [1:0] {
    MUX_OFF     = 2'd0,
    MUX_STATIC  = 2'd1,
    MUX_DUPLEX  = 2'd2,
    MUX_TRIPLEX = 2'd3
  } mux_e;

endpackage

// File: rtl/lcd_level_seq_timebase.sv
module lcd_level_seq_timebase
  import lcd_level_seq_pkg::*;
#(
  parameter int FRAME_DIV = 2400,
  parameter int CNT_W     = $clog2(FRAME_DIV / 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             pwr_dn,
  output logic             run_q,
  output mux_e             mode_q,
  output logic             phase_q,
  output logic [1:0]       slot_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             frame_end
);

  // last count of a half slot for each plane count
  localparam logic [CNT_W-1:0] HALF1_MAX = CNT_W'(FRAME_DIV / 2 - 1);
  localparam logic [CNT_W-1:0] HALF2_MAX = CNT_W'(FRAME_DIV / 4 - 1);
  localparam logic [CNT_W-1:0] HALF3_MAX = CNT_W'(FRAME_DIV / 6 - 1);

  logic             go;
  logic             advance;
  logic             half_last;
  logic             slot_last;
  logic [CNT_W-1:0] half_max;
  logic [1:0]       slot_max;
  logic [CNT_W-1:0] cnt_d;
  logic             phase_d;
  logic [1:0]       slot_d;

  always_comb begin
    go = !pwr_dn && (mode != 2'b00) && (mode == mode_q);
    case (mode_q)
      MUX_DUPLEX: begin
        half_max = HALF2_MAX;
        slot_max = 2'd1;
      end
      MUX_TRIPLEX: begin
        half_max = HALF3_MAX;
        slot_max = 2'd2;
      end
      default: begin
        half_max = HALF1_MAX;
        slot_max = 2'd0;
      end
    endcase
    half_last = (cnt_q == half_max);
    slot_last = (slot_q == slot_max);
    advance   = go && run_q;

    cnt_d   = cnt_q;
    phase_d = phase_q;
    slot_d  = slot_q;
    if (!advance) begin
      cnt_d   = '0;
      phase_d = 1'b0;
      slot_d  = 2'd0;
    end else if (half_last) begin
      cnt_d   = '0;
      phase_d = ~phase_q;
      if (phase_q) begin
        slot_d = slot_last ? 2'd0 : slot_q + 2'd1;
      end
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    frame_end = advance && half_last && phase_q && slot_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      mode_q  <= MUX_OFF;
      phase_q <= 1'b0;
      slot_q  <= 2'd0;
      cnt_q   <= '0;
    end else begin
      run_q   <= go;
      mode_q  <= mux_e'(mode);
      phase_q <= phase_d;
      slot_q  <= slot_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/lcd_level_seq_latch.sv
module lcd_level_seq_latch #(
  parameter int DW = 96
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_end,
  input  logic          hold,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] disp_q
);

  logic          load_en;
  logic [DW-1:0] disp_d;

  always_comb begin
    load_en = frame_end && !hold;
    disp_d  = load_en ? din : disp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_q <= '0;
    end else if (load_en) begin
      disp_q <= disp_d;
    end
  end

endmodule

// File: rtl/lcd_level_seq_bpdrv.sv
module lcd_level_seq_bpdrv
  import lcd_level_seq_pkg::*;
(
  input  logic                    run_q,
  input  mux_e                    mode_q,
  input  logic [1:0]              slot_q,
  input  logic                    phase_q,
  output logic [PLANES*LVL_W-1:0] bp_lvl
);

  for (genvar k = 0; k < PLANES; k++) begin : g_plane
    lvl_e lv;
    always_comb begin
      if (!run_q) begin
        lv = LV_VSS;
      end else if (slot_q == 2'(k)) begin
        lv = phase_q ? LV_VSS : LV_VLCD;
      end else begin
        case (mode_q)
          MUX_DUPLEX:  lv = LV_HALF;
          MUX_TRIPLEX: lv = phase_q ? LV_TWOTHIRD : LV_THIRD;
          default:     lv = LV_VSS;
        endcase
      end
    end
    assign bp_lvl[k*LVL_W +: LVL_W] = lv;
  end

endmodule

// File: rtl/lcd_level_seq_segdrv.sv
module lcd_level_seq_segdrv
  import lcd_level_seq_pkg::*;
#(
  parameter int SEG_COUNT = 32
) (
  input  logic                        run_q,
  input  mux_e                        mode_q,
  input  logic [1:0]                  slot_q,
  input  logic                        phase_q,
  input  logic [PLANES*SEG_COUNT-1:0] disp_q,
  output logic [SEG_COUNT*LVL_W-1:0]  seg_lvl
);

  for (genvar n = 0; n < SEG_COUNT; n++) begin : g_seg
    logic pix;
    lvl_e lv;
    always_comb begin
      case (slot_q)
        2'd0:    pix = disp_q[n];
        2'd1:    pix = disp_q[SEG_COUNT + n];
        default: pix = disp_q[2*SEG_COUNT + n];
      endcase
      if (!run_q) begin
        lv = LV_VSS;
      end else if (pix) begin
        lv = phase_q ? LV_VLCD : LV_VSS;
      end else begin
        case (mode_q)
          MUX_STATIC: lv = phase_q ? LV_VSS : LV_VLCD;
          MUX_DUPLEX: lv = LV_HALF;
          default:    lv = phase_q ? LV_THIRD : LV_TWOTHIRD;
        endcase
      end
    end
    assign seg_lvl[n*LVL_W +: LVL_W] = lv;
  end

endmodule

// File: rtl/lcd_level_seq.sv
module lcd_level_seq
  import lcd_level_seq_pkg::*;
#(
  parameter int FRAME_DIV = 2400,
  parameter int SEG_COUNT = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pwr_dn,
  input  logic [1:0]                  mode,
  input  logic                        shift_en,
  input  logic [PLANES*SEG_COUNT-1:0] shift_data,
  output logic [PLANES*LVL_W-1:0]     bp_lvl,
  output logic [SEG_COUNT*LVL_W-1:0]  seg_lvl
);

  localparam int DW    = PLANES * SEG_COUNT;
  localparam int CNT_W = $clog2(FRAME_DIV / 2);

  logic             run_q;
  mux_e             mode_q;
  logic             phase_q;
  logic [1:0]       slot_q;
  logic [CNT_W-1:0] cnt_q;
  logic             frame_end;
  logic [DW-1:0]    disp_q;

  lcd_level_seq_timebase #(
    .FRAME_DIV (FRAME_DIV),
    .CNT_W     (CNT_W)
  ) u_timebase (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .pwr_dn    (pwr_dn),
    .run_q     (run_q),
    .mode_q    (mode_q),
    .phase_q   (phase_q),
    .slot_q    (slot_q),
    .cnt_q     (cnt_q),
    .frame_end (frame_end)
  );

  lcd_level_seq_latch #(
    .DW (DW)
  ) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .hold      (shift_en),
    .din       (shift_data),
    .disp_q    (disp_q)
  );

  lcd_level_seq_bpdrv u_bpdrv (
    .run_q   (run_q),
    .mode_q  (mode_q),
    .slot_q  (slot_q),
    .phase_q (phase_q),
    .bp_lvl  (bp_lvl)
  );

  lcd_level_seq_segdrv #(
    .SEG_COUNT (SEG_COUNT)
  ) u_segdrv (
    .run_q   (run_q),
    .mode_q  (mode_q),
    .slot_q  (slot_q),
    .phase_q (phase_q),
    .disp_q  (disp_q),
    .seg_lvl (seg_lvl)
  );

endmodule

// File: rtl/lcd_level_seq_chk.sv
module lcd_level_seq_chk #(
  parameter int SEG_COUNT = 32,
  parameter int CNT_W     = 11
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   pwr_dn,
  input logic [1:0]             mode,
  input logic                   shift_en,
  input logic [8:0]             bp_lvl,
  input logic [SEG_COUNT*3-1:0] seg_lvl,
  input logic [SEG_COUNT*3-1:0] disp_q,
  input logic                   run_q,
  input logic [1:0]             mode_q,
  input logic [1:0]             slot_q,
  input logic                   phase_q,
  input logic [CNT_W-1:0]       cnt_q
);

  logic [1:0] plane_cnt;
  always_comb begin
    plane_cnt = (mode_q == 2'd3) ? 2'd3 : ((mode_q == 2'd2) ? 2'd2 : 2'd1);
  end

  a_r2_pd_blank: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (bp_lvl == '0 && seg_lvl == '0));

  a_r2_test_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> (bp_lvl == '0 && seg_lvl == '0));

  a_r3_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (slot_q < plane_cnt));

  a_r4_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> ($countones({bp_lvl[2:0] == 3'd4, bp_lvl[5:3] == 3'd4,
                           bp_lvl[8:6] == 3'd4}) <= 1));

  a_r5_static_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && mode_q == 2'b01) |-> (bp_lvl[5:3] == 3'd0 && bp_lvl[8:6] == 3'd0));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> $stable(disp_q));

  a_r9_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(disp_q) |-> (cnt_q == '0 && phase_q == 1'b0 && slot_q == 2'd0));

  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != mode_q) |=> !run_q);

endmodule

bind lcd_level_seq lcd_level_seq_chk #(
  .SEG_COUNT (SEG_COUNT),
  .CNT_W     (CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwr_dn   (pwr_dn),
  .mode     (mode),
  .shift_en (shift_en),
  .bp_lvl   (bp_lvl),
  .seg_lvl  (seg_lvl),
  .disp_q   (disp_q),
  .run_q    (run_q),
  .mode_q   (mode_q),
  .slot_q   (slot_q),
  .phase_q  (phase_q),
  .cnt_q    (cnt_q)
);

// File: tb/lcd_level_seq_bench.sv
module lcd_level_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int FRAME      = 48;
  localparam int SEGN       = 32;
  localparam int DW         = 3 * SEGN;

  logic          clk;
  logic          rst_n;
  logic          pwr_dn;
  logic [1:0]    mode;
  logic          shift_en;
  logic [DW-1:0] shift_data;
  logic [8:0]    bp_lvl;
  logic [SEGN*3-1:0] seg_lvl;

  lcd_level_seq #(
    .FRAME_DIV (FRAME),
    .SEG_COUNT (SEGN)
  ) u_lcd_level_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_dn     (pwr_dn),
    .mode       (mode),
    .shift_en   (shift_en),
    .shift_data (shift_data),
    .bp_lvl     (bp_lvl),
    .seg_lvl    (seg_lvl)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  string g_tag = "";

  // bench model of the configuration it has applied
  int            m_mode;
  bit            m_pd;
  int            m_t;
  int            m_blank;
  logic [DW-1:0] m_latch;
  // values to drive at the next tick
  int            p_mode;
  bit            p_pd;
  bit            p_en;
  logic [DW-1:0] p_data;

  function automatic int planes(int m);
    return (m == 3) ? 3 : ((m == 2) ? 2 : 1);
  endfunction

  function automatic logic [2:0] bp_exp(int m, int k, int slot, bit ph);
    if (k == slot) return ph ? 3'd0 : 3'd4;
    if (m == 1) return 3'd0;
    if (m == 2) return 3'd2;
    return ph ? 3'd3 : 3'd1;
  endfunction

  function automatic logic [2:0] seg_exp(int m, bit on, bit ph);
    if (on) return ph ? 3'd4 : 3'd0;
    if (m == 1) return ph ? 3'd0 : 3'd4;
    if (m == 2) return 3'd2;
    return ph ? 3'd1 : 3'd3;
  endfunction

  function automatic bit model_active();
    return !m_pd && m_mode != 0 && m_blank == 0;
  endfunction

  task automatic do_tick();
    logic [8:0]        ebp;
    logic [SEGN*3-1:0] eseg;
    bit act, cfg_chg;
    int pos, hl, h, slot;
    bit ph;
    @(negedge clk);
    act  = model_active();
    ebp  = '0;
    eseg = '0;
    if (act) begin
      pos  = m_t % FRAME;
      hl   = FRAME / (2 * planes(m_mode));
      h    = pos / hl;
      slot = h / 2;
      ph   = bit'(h % 2);
      for (int k = 0; k < 3; k++) ebp[k*3 +: 3] = bp_exp(m_mode, k, slot, ph);
      for (int n = 0; n < SEGN; n++)
        eseg[n*3 +: 3] = seg_exp(m_mode, m_latch[slot*SEGN + n], ph);
    end
    n_checks++;
    if (bp_lvl !== ebp) begin
      n_errors++;
      $display("FAIL %s (%s) t=%0d bp_lvl got %h expected %h", g_tag,
               act ? "R4 R5" : "R2 R10", m_t, bp_lvl, ebp);
    end
    n_checks++;
    if (seg_lvl !== eseg) begin
      n_errors++;
      $display("FAIL %s (%s) t=%0d seg_lvl got %h expected %h", g_tag,
               act ? "R6 R7 R8" : "R2 R10", m_t, seg_lvl, eseg);
    end
    cfg_chg    = (p_mode != m_mode) || (p_pd != m_pd);
    mode       = 2'(p_mode);
    pwr_dn     = p_pd;
    shift_en   = p_en;
    shift_data = p_data;
    if (act && !cfg_chg && ((m_t + 1) % FRAME == 0) && !p_en) m_latch = p_data;
    if (cfg_chg) begin
      m_blank = (p_mode != m_mode) ? 1 : 0;
      m_t     = 0;
      m_mode  = p_mode;
      m_pd    = p_pd;
    end else if (m_blank > 0) begin
      m_blank--;
    end else if (act) begin
      m_t++;
    end
  endtask

  task automatic run(int n);
    repeat (n) do_tick();
  endtask

  function automatic logic [DW-1:0] rnd_data();
    return {$urandom(), $urandom(), $urandom()};
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1cd0));
    // R1: reset state
    g_tag      = "R1 reset";
    rst_n      = 1'b0;
    mode       = 2'd3;
    pwr_dn     = 1'b0;
    shift_en   = 1'b1;
    shift_data = '1;
    p_mode = 3; p_pd = 0; p_en = 1; p_data = '1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      n_checks++;
      if (bp_lvl !== '0 || seg_lvl !== '0) begin
        n_errors++;
        $display("FAIL R1 reset outputs got %h/%h expected 0", bp_lvl, seg_lvl);
      end
    end
    rst_n   = 1'b1;
    m_mode  = 3; m_pd = 0; m_t = 0; m_blank = 1; m_latch = '0;

    // R10 start-up blank, R9 hold while shifting: latch stays cleared
    g_tag = "R9 R10 hold during shift";
    run(2 * FRAME + 1);
    g_tag  = "R8 R9 load when idle";
    p_en   = 0;
    p_data = 96'h0000_ffff_00ff_0f0f_3333_5555;
    run(2 * FRAME);

    // directed per mode and pattern
    for (int m = 1; m <= 3; m++) begin
      for (int pat = 0; pat < 3; pat++) begin
        g_tag  = $sformatf("R3 R5 R6 R7 mode %0d pat %0d", m, pat);
        p_mode = m;
        p_en   = 0;
        p_data = (pat == 0) ? '1 : ((pat == 1) ? {24{4'ha}} : rnd_data());
        run(2 * FRAME + 5);
      end
    end

    // R9 boundary: enable low only on the frame's closing clock
    g_tag = "R9 one-cycle window";
    p_mode = 3; p_en = 1;
    run(3);
    while (!(model_active() && ((m_t + 1) % FRAME == 0))) do_tick();
    p_en = 0; p_data = rnd_data();
    do_tick();
    p_en = 1; p_data = rnd_data();
    run(2 * FRAME);
    // R9 boundary: enable high only on the closing clock blocks the load
    g_tag = "R9 blocked at boundary";
    p_en = 0;
    while (!(model_active() && ((m_t + 1) % FRAME == 0))) do_tick();
    p_en = 1; p_data = rnd_data();
    do_tick();
    p_en = 0;
    run(2 * FRAME);

    // R2 power-down and test mode, then restart
    g_tag = "R2 power-down";
    p_pd = 1;
    run(100);
    p_pd = 0;
    run(FRAME + 7);
    g_tag = "R2 mode 00";
    p_mode = 0;
    run(60);
    p_mode = 2;
    run(FRAME + 3);
    // R10 mode change mid-slot
    g_tag = "R10 mid-slot change";
    run(13);
    p_mode = 1;
    run(FRAME + 2);

    // random phase
    g_tag = "R3 random";
    for (int i = 0; i < 8000; i++) begin
      if ($urandom() % 16 == 0) p_en = !p_en;
      if ($urandom() % 8 == 0) p_data = rnd_data();
      if ($urandom() % 300 == 0) begin
        p_mode = int'($urandom() % 4);
        p_pd   = ($urandom() % 6 == 0);
      end
      do_tick();
    end
    finish_run();
  end

endmodule